// File: doc/BRIEF.md
# DMA Engine Lifecycle Controller

This block is the event-driven sequencer for a send-DMA engine. Each clock cycle it may receive one event on a one-hot input vector. There are eleven event kinds:

- go down and go start
- hardware started and go running
- software cleaned and hardware cleaned
- hardware halted and go idle
- a soft error halt and a hard error halt
- a timer tick

From these events the block moves the engine through seven phases: hardware down, start-up wait, idle, running, halt wait, hardware clean-up wait and software clean-up wait. It records a sticky run request. That request decides whether a finished start-up lands in idle or in running.

The block drives four registered engine control bits: enable, interrupt enable, halt and drain. It also emits single-cycle strobes that ask the surrounding logic to take a start-up reference, start the hardware, clean the hardware, clean the software state, or tear the engine down. The clean-up and start-up work itself happens outside this block. That outside logic reports back with the matching completion events.

The two error halts recover differently. The soft error halt jumps straight to software clean-up. The hard error halt first waits for the engine to halt, like a go-idle request, but it leaves the run request untouched.

Top module: `dma_lifecycle_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs read as follows: state 0 (hardware down), run request 0, all control bits 0, all strobes 0, last event 15.
- R2: An event is valid only when exactly one bit of `evt_i` is set. Bit positions are: 0 go down, 1 go start, 2 hardware started, 3 go running, 4 software cleaned, 5 hardware cleaned, 6 hardware halted, 7 go idle, 8 soft error halt, 9 hard error halt, 10 timer tick. An all-zero or multi-bit vector changes nothing, including the last-event record.
- R3: State codes are: 0 down, 1 start-up wait, 2 idle, 3 software clean-up wait, 4 hardware clean-up wait, 5 halt wait, 6 running. In down, the following hold:
  - go start enters start-up wait and pulses `start_ref_o`;
  - go running does the same and also sets the run request;
  - software cleaned stays in down and pulses `teardown_o`.
- R4: In start-up wait, hardware started enters running if the run request is set, and enters idle otherwise. Go running and go idle only set and clear the run request.
- R5: In idle, go running enters running and sets the run request.
- R6: In running, go idle enters halt wait and clears the run request. Hardware halted enters software clean-up wait and pulses `sw_clean_o`.
- R7: In running, the soft error halt enters software clean-up wait and pulses `sw_clean_o`. The hard error halt enters halt wait and leaves the run request unchanged.
- R8: Halt wait plus hardware halted enters hardware clean-up wait and pulses `hw_clean_o`. Hardware clean-up wait plus hardware cleaned enters software clean-up wait and pulses `sw_clean_o`.
- R9: Software clean-up wait plus software cleaned enters start-up wait and pulses `hw_start_o`.
- R10: Go down always enters down. From start-up wait or idle it pulses `teardown_o`. From running, halt wait or hardware clean-up wait it pulses `sw_clean_o`. From software clean-up wait it pulses nothing.
- R11: In halt wait and in both clean-up waits, go running sets the run request and go idle clears it, with no state change.
- R12: An event not listed for the current state changes neither state nor run request, and the timer tick never does. Every valid event, including ignored ones, is copied to `last_evt_o` as its bit index.
- R13: The control bits are decoded from state:
  - enable and interrupt enable are high exactly in running;
  - halt is high exactly in halt wait;
  - drain is high exactly in the two clean-up waits.

  They change in the same cycle as `state_o`.
- R14: All outputs update on the clock edge that samples the event. Each strobe lasts one cycle, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 11 | One-hot event pulses |
| state_o | output | 3 | Current phase code |
| run_req_o | output | 1 | Sticky run request |
| last_evt_o | output | 4 | Index of the last valid event, 15 for none |
| eng_en_o | output | 1 | Engine enable |
| eng_irq_en_o | output | 1 | Engine interrupt enable |
| eng_halt_o | output | 1 | Engine halt request |
| eng_drain_o | output | 1 | Engine drain request |
| start_ref_o | output | 1 | Start-up reference strobe |
| hw_start_o | output | 1 | Hardware start-up strobe (disarms send buffers) |
| hw_clean_o | output | 1 | Hardware clean-up strobe |
| sw_clean_o | output | 1 | Software clean-up strobe |
| teardown_o | output | 1 | Teardown strobe |

## Verification
The hardest situations to reach are the late recovery phases with the run request held at a chosen value. Examples are a hard error halt taken while the request is set, and a go down from hardware clean-up wait. Each needs a precise chain of events from reset.

The stimulus table is therefore one long scenario. It walks down, start-up, idle, running, halt, hardware clean-up, software clean-up and back. Ignored and malformed events are inserted at points where they could do harm. Later rows restart the engine with the request first cleared and then set, so that both start-up outcomes and every go-down origin are reached.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    localparam int NUM_EVT    = 11;
    localparam int EVT_IDX_W  = 4;
    localparam int STATE_W    = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_DOWN       = 3'd0,
        ST_START_WAIT = 3'd1,
        ST_IDLE       = 3'd2,
        ST_SWCLN_WAIT = 3'd3,
        ST_HWCLN_WAIT = 3'd4,
        ST_HALT_WAIT  = 3'd5,
        ST_RUN        = 3'd6
    } lc_state_e;

    typedef enum logic [EVT_IDX_W-1:0] {
        EV_GO_DOWN    = 4'd0,
        EV_GO_START   = 4'd1,
        EV_HW_STARTED = 4'd2,
        EV_GO_RUN     = 4'd3,
        EV_SW_CLEANED = 4'd4,
        EV_HW_CLEANED = 4'd5,
        EV_HW_HALTED  = 4'd6,
        EV_GO_IDLE    = 4'd7,
        EV_ERR_SOFT   = 4'd8,
        EV_ERR_HARD   = 4'd9,
        EV_TICK       = 4'd10,
        EV_NONE       = 4'd15
    } lc_event_e;

    typedef struct packed {
        logic start_ref;
        logic hw_start;
        logic hw_clean;
        logic sw_clean;
        logic teardown;
    } lc_strobe_t;

    typedef struct packed {
        logic en;
        logic irq_en;
        logic halt;
        logic drain;
    } lc_ctrl_t;

endpackage

// File: rtl/dlc_evt_decode.sv
module dlc_evt_decode
    import dlc_pkg::*;
#(
    parameter int N_EVT = NUM_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    output lc_event_e        evt_o,
    output lc_event_e        last_evt_q
);

    always_comb begin
        evt_o = EV_NONE;
        if ($onehot(evt_i)) begin
            for (int i = 0; i < N_EVT; i++) begin
                if (evt_i[i]) begin
                    evt_o = lc_event_e'(EVT_IDX_W'(i));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_evt_q <= EV_NONE;
        end else if (evt_o != EV_NONE) begin
            last_evt_q <= evt_o;
        end
    end

    // R2
    bad_evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot(evt_i) |=> $stable(last_evt_q));

    // R12
    evt_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(evt_i) |=> last_evt_q != EV_NONE);

endmodule

// File: rtl/dlc_fsm.sv
module dlc_fsm
    import dlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lc_event_e  evt,
    output lc_state_e  state_q,
    output lc_state_e  state_d,
    output logic       run_req_q,
    output lc_strobe_t strobe_q
);

    logic       run_req_d;
    lc_strobe_t strobe_d;

    // Next-state, run-request and strobe decode
    always_comb begin
        state_d   = state_q;
        run_req_d = run_req_q;
        strobe_d  = '0;
        unique case (state_q)
            ST_DOWN: begin
                case (evt)
                    EV_GO_RUN: begin
                        run_req_d          = 1'b1;
                        state_d            = ST_START_WAIT;
                        strobe_d.start_ref = 1'b1;
                    end
                    EV_GO_START: begin
                        state_d            = ST_START_WAIT;
                        strobe_d.start_ref = 1'b1;
                    end
                    EV_SW_CLEANED: strobe_d.teardown = 1'b1;
                    default: ;
                endcase
            end
            ST_START_WAIT: begin
                case (evt)
                    EV_GO_DOWN: begin
                        state_d           = ST_DOWN;
                        strobe_d.teardown = 1'b1;
                    end
                    EV_HW_STARTED: state_d = run_req_q ? ST_RUN : ST_IDLE;
                    EV_GO_RUN:     run_req_d = 1'b1;
                    EV_GO_IDLE:    run_req_d = 1'b0;
                    default: ;
                endcase
            end
            ST_IDLE: begin
                case (evt)
                    EV_GO_DOWN: begin
                        state_d           = ST_DOWN;
                        strobe_d.teardown = 1'b1;
                    end
                    EV_GO_RUN: begin
                        state_d   = ST_RUN;
                        run_req_d = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_SWCLN_WAIT: begin
                case (evt)
                    EV_GO_DOWN: state_d = ST_DOWN;
                    EV_SW_CLEANED: begin
                        state_d           = ST_START_WAIT;
                        strobe_d.hw_start = 1'b1;
                    end
                    EV_GO_RUN:  run_req_d = 1'b1;
                    EV_GO_IDLE: run_req_d = 1'b0;
                    default: ;
                endcase
            end
            ST_HWCLN_WAIT: begin
                case (evt)
                    EV_GO_DOWN: begin
                        state_d           = ST_DOWN;
                        strobe_d.sw_clean = 1'b1;
                    end
                    EV_HW_CLEANED: begin
                        state_d           = ST_SWCLN_WAIT;
                        strobe_d.sw_clean = 1'b1;
                    end
                    EV_GO_RUN:  run_req_d = 1'b1;
                    EV_GO_IDLE: run_req_d = 1'b0;
                    default: ;
                endcase
            end
            ST_HALT_WAIT: begin
                case (evt)
                    EV_GO_DOWN: begin
                        state_d           = ST_DOWN;
                        strobe_d.sw_clean = 1'b1;
                    end
                    EV_HW_HALTED: begin
                        state_d           = ST_HWCLN_WAIT;
                        strobe_d.hw_clean = 1'b1;
                    end
                    EV_GO_RUN:  run_req_d = 1'b1;
                    EV_GO_IDLE: run_req_d = 1'b0;
                    default: ;
                endcase
            end
            ST_RUN: begin
                case (evt)
                    EV_GO_DOWN: begin
                        state_d           = ST_DOWN;
                        strobe_d.sw_clean = 1'b1;
                    end
                    EV_HW_HALTED, EV_ERR_SOFT: begin
                        state_d           = ST_SWCLN_WAIT;
                        strobe_d.sw_clean = 1'b1;
                    end
                    EV_GO_IDLE: begin
                        state_d   = ST_HALT_WAIT;
                        run_req_d = 1'b0;
                    end
                    EV_ERR_HARD: state_d = ST_HALT_WAIT;
                    default: ;
                endcase
            end
            default: state_d = ST_DOWN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DOWN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_req_q <= 1'b0;
            strobe_q  <= '0;
        end else begin
            run_req_q <= run_req_d;
            strobe_q  <= strobe_d;
        end
    end

    // R14
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_q));

    // R4
    startup_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START_WAIT && evt == EV_HW_STARTED)
        |=> (state_q == ($past(run_req_q) ? ST_RUN : ST_IDLE)));

    // R12
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_TICK) |=> ($stable(state_q) && $stable(run_req_q)));

    // R10
    go_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_GO_DOWN) |=> (state_q == ST_DOWN));

    // R6
    run_to_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && evt == EV_GO_IDLE)
        |=> (state_q == ST_HALT_WAIT && !run_req_q));

    // R9
    hw_start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q.hw_start |-> (state_q == ST_START_WAIT));

endmodule

// File: rtl/dlc_ctrl_decode.sv
module dlc_ctrl_decode
    import dlc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lc_state_e state_d,
    output lc_ctrl_t  ctrl_q
);

    lc_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = '0;
        unique case (state_d)
            ST_RUN: begin
                ctrl_d.en     = 1'b1;
                ctrl_d.irq_en = 1'b1;
            end
            ST_HALT_WAIT:                 ctrl_d.halt  = 1'b1;
            ST_SWCLN_WAIT, ST_HWCLN_WAIT: ctrl_d.drain = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R13
    ctrl_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_q.en, ctrl_q.halt, ctrl_q.drain}));

endmodule

// File: rtl/dma_lifecycle_ctrl.sv
module dma_lifecycle_ctrl
    import dlc_pkg::*;
#(
    parameter int N_EVT = NUM_EVT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    output logic [2:0]       state_o,
    output logic             run_req_o,
    output logic [3:0]       last_evt_o,
    output logic             eng_en_o,
    output logic             eng_irq_en_o,
    output logic             eng_halt_o,
    output logic             eng_drain_o,
    output logic             start_ref_o,
    output logic             hw_start_o,
    output logic             hw_clean_o,
    output logic             sw_clean_o,
    output logic             teardown_o
);

    lc_event_e  evt;
    lc_event_e  last_evt;
    lc_state_e  state_q;
    lc_state_e  state_d;
    logic       run_req;
    lc_strobe_t strobe;
    lc_ctrl_t   ctrl;

    dlc_evt_decode #(.N_EVT(N_EVT)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .evt_o      (evt),
        .last_evt_q (last_evt)
    );

    dlc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .state_q   (state_q),
        .state_d   (state_d),
        .run_req_q (run_req),
        .strobe_q  (strobe)
    );

    dlc_ctrl_decode u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .ctrl_q  (ctrl)
    );

    assign state_o      = state_q;
    assign run_req_o    = run_req;
    assign last_evt_o   = last_evt;
    assign eng_en_o     = ctrl.en;
    assign eng_irq_en_o = ctrl.irq_en;
    assign eng_halt_o   = ctrl.halt;
    assign eng_drain_o  = ctrl.drain;
    assign start_ref_o  = strobe.start_ref;
    assign hw_start_o   = strobe.hw_start;
    assign hw_clean_o   = strobe.hw_clean;
    assign sw_clean_o   = strobe.sw_clean;
    assign teardown_o   = strobe.teardown;

    // R13
    run_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_en_o == (state_q == ST_RUN));

    // R13
    drain_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_drain_o == (state_q == ST_SWCLN_WAIT || state_q == ST_HWCLN_WAIT));

    // R2
    bad_evt_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot(evt_i) |=> ($stable(state_o) && $stable(run_req_o)));

    // R7
    hard_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $onehot(evt_i) && evt_i[9])
        |=> (state_q == ST_HALT_WAIT && $stable(run_req_o)));

endmodule

// File: tb/tb_dma_lifecycle_ctrl.sv
module tb_dma_lifecycle_ctrl;
    import dlc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP      = 42;

    localparam logic [4:0] SN = 5'b00000;
    localparam logic [4:0] SR = 5'b10000;
    localparam logic [4:0] HS = 5'b01000;
    localparam logic [4:0] HC = 5'b00100;
    localparam logic [4:0] SC = 5'b00010;
    localparam logic [4:0] TD = 5'b00001;

    // {event index, expected state, expected run request, expected strobes}
    // index 14 = two bits set, 15 = no bits set
    localparam logic [12:0] VEC [NSTEP] = '{
        {4'd1,  3'd1, 1'b0, SR},  // R3 go start from down
        {4'd10, 3'd1, 1'b0, SN},  // R12 tick
        {4'd2,  3'd2, 1'b0, SN},  // R4 to idle
        {4'd7,  3'd2, 1'b0, SN},  // R12 ignored in idle
        {4'd3,  3'd6, 1'b1, SN},  // R5
        {4'd1,  3'd6, 1'b1, SN},  // R12 ignored in running
        {4'd14, 3'd6, 1'b1, SN},  // R2 multi-bit
        {4'd7,  3'd5, 1'b0, SN},  // R6 go idle
        {4'd3,  3'd5, 1'b1, SN},  // R11
        {4'd6,  3'd4, 1'b1, HC},  // R8
        {4'd5,  3'd3, 1'b1, SC},  // R8
        {4'd7,  3'd3, 1'b0, SN},  // R11
        {4'd4,  3'd1, 1'b0, HS},  // R9
        {4'd3,  3'd1, 1'b1, SN},  // R4 set request
        {4'd2,  3'd6, 1'b1, SN},  // R4 to running
        {4'd8,  3'd3, 1'b1, SC},  // R7 soft error
        {4'd4,  3'd1, 1'b1, HS},  // R9
        {4'd2,  3'd6, 1'b1, SN},  // R4
        {4'd9,  3'd5, 1'b1, SN},  // R7 hard error keeps request
        {4'd0,  3'd0, 1'b1, SC},  // R10 from halt wait
        {4'd4,  3'd0, 1'b1, TD},  // R3 teardown
        {4'd3,  3'd1, 1'b1, SR},  // R3 go running from down
        {4'd0,  3'd0, 1'b1, TD},  // R10 from start-up wait
        {4'd6,  3'd0, 1'b1, SN},  // R12 ignored in down
        {4'd1,  3'd1, 1'b1, SR},  // R3
        {4'd2,  3'd6, 1'b1, SN},  // R4
        {4'd6,  3'd3, 1'b1, SC},  // R6 hardware halted
        {4'd0,  3'd0, 1'b1, SN},  // R10 from software clean-up wait
        {4'd15, 3'd0, 1'b1, SN},  // R2 empty vector
        {4'd1,  3'd1, 1'b1, SR},  // R3
        {4'd7,  3'd1, 1'b0, SN},  // R4 clear request
        {4'd2,  3'd2, 1'b0, SN},  // R4 to idle
        {4'd0,  3'd0, 1'b0, TD},  // R10 from idle
        {4'd3,  3'd1, 1'b1, SR},  // R3
        {4'd2,  3'd6, 1'b1, SN},  // R4
        {4'd7,  3'd5, 1'b0, SN},  // R6
        {4'd6,  3'd4, 1'b0, HC},  // R8
        {4'd0,  3'd0, 1'b0, SC},  // R10 from hardware clean-up wait
        {4'd1,  3'd1, 1'b0, SR},  // R3
        {4'd3,  3'd1, 1'b1, SN},  // R4
        {4'd2,  3'd6, 1'b1, SN},  // R4
        {4'd0,  3'd0, 1'b1, SC}   // R10 from running
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_EVT-1:0] evt_i;
    logic [2:0]         state_o;
    logic               run_req_o;
    logic [3:0]         last_evt_o;
    logic               eng_en_o, eng_irq_en_o, eng_halt_o, eng_drain_o;
    logic               start_ref_o, hw_start_o, hw_clean_o, sw_clean_o, teardown_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_lifecycle_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .state_o      (state_o),
        .run_req_o    (run_req_o),
        .last_evt_o   (last_evt_o),
        .eng_en_o     (eng_en_o),
        .eng_irq_en_o (eng_irq_en_o),
        .eng_halt_o   (eng_halt_o),
        .eng_drain_o  (eng_drain_o),
        .start_ref_o  (start_ref_o),
        .hw_start_o   (hw_start_o),
        .hw_clean_o   (hw_clean_o),
        .sw_clean_o   (sw_clean_o),
        .teardown_o   (teardown_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [NUM_EVT-1:0] evt_vec(input int idx);
        if (idx < NUM_EVT) return NUM_EVT'(1) << idx;
        if (idx == 14)     return NUM_EVT'(11'b000_0000_1010);
        return '0;
    endfunction

    function automatic string tag_for(input int prev, input int idx, input int st,
                                      input bit pfl, input bit fl, input logic [4:0] sb);
        if (idx > 10)                               return "R2";
        if (idx == 0)                               return "R10";
        if (idx == 10)                              return "R12";
        if (st == prev && fl == pfl && sb == SN)    return "R12";
        if (prev == 0)                              return "R3";
        if (prev == 1)                              return "R4";
        if (prev == 2)                              return "R5";
        if (prev == 6)                              return (idx == 8 || idx == 9) ? "R7" : "R6";
        if (prev == 3 && idx == 4)                  return "R9";
        if ((prev == 5 && idx == 6) || (prev == 4 && idx == 5)) return "R8";
        return "R11";
    endfunction

    task automatic check_outputs(input string tag, input int st, input bit fl,
                                 input logic [4:0] sb, input int last);
        logic [4:0] act_sb;
        act_sb = {start_ref_o, hw_start_o, hw_clean_o, sw_clean_o, teardown_o};
        chk(state_o == 3'(st), tag, "state", int'(state_o), st);
        chk(run_req_o == fl, tag, "run_req", int'(run_req_o), int'(fl));
        chk(act_sb == sb, tag, "strobes", int'(act_sb), int'(sb));
        chk(eng_en_o == (st == 6), "R13", "enable", int'(eng_en_o), int'(st == 6));
        chk(eng_irq_en_o == (st == 6), "R13", "irq_enable", int'(eng_irq_en_o), int'(st == 6));
        chk(eng_halt_o == (st == 5), "R13", "halt", int'(eng_halt_o), int'(st == 5));
        chk(eng_drain_o == (st == 3 || st == 4), "R13", "drain",
            int'(eng_drain_o), int'(st == 3 || st == 4));
        chk(last_evt_o == 4'(last), "R12", "last_event", int'(last_evt_o), last);
    endtask

    task automatic apply_event(input int idx);
        @(negedge clk);
        evt_i = evt_vec(idx);
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R14 watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int prev_st;
        bit prev_fl;
        int last;
        rst_n = 1'b0;
        evt_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state, during reset
        check_outputs("R1", 0, 1'b0, SN, 15);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, after release
        check_outputs("R1", 0, 1'b0, SN, 15);

        prev_st = 0;
        prev_fl = 1'b0;
        last    = 15;
        for (int s = 0; s < NSTEP; s++) begin
            int idx, st;
            bit fl;
            logic [4:0] sb;
            idx = int'(VEC[s][12:9]);
            st  = int'(VEC[s][8:6]);
            fl  = VEC[s][5];
            sb  = VEC[s][4:0];
            apply_event(idx);
            if (idx <= 10) last = idx;
            check_outputs(tag_for(prev_st, idx, st, prev_fl, fl, sb), st, fl, sb, last);
            prev_st = st;
            prev_fl = fl;
        end

        // R14 strobe lasts a single cycle
        apply_event(1);
        check_outputs("R14", 1, 1'b1, SR, 1);
        @(negedge clk);
        check_outputs("R14", 1, 1'b1, SN, 1);

        // R12 tick in start-up wait leaves everything but the record
        apply_event(10);
        check_outputs("R12", 1, 1'b1, SN, 10);

        // R4 start-up with request held enters running
        apply_event(2);
        check_outputs("R4", 6, 1'b1, SN, 2);

        // R1 asynchronous reset from running
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_outputs("R1", 0, 1'b0, SN, 15);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1", 0, 1'b0, SN, 15);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule